// File: doc/BRIEF.md
# Core Interrupt Mask, Latch and Pending Controller

This block sits beside a processor core and decides when an interrupt is taken. Each source line, the core timer among them, sets a bit in an event-latch register. The bit stays set even when that source is gated off by the enable-mask register, so no event is lost while software has interrupts blocked. A latched event whose enable bit is set is granted to the core. The grant must also outrank every service routine that is already running.

When the block grants an event, it clears that event's latch bit and sets the matching bit in a service-active register. In the following cycle it raises a one-cycle grant strobe together with the index of the granted source. A lower index always wins. Nesting arises because a more urgent source can be granted while a less urgent routine is still marked active. A return strobe from the core ends the most urgent active routine.

Software reaches the three registers over a simple write/read bus. The mask can be read and written. The latch is cleared by writing ones to it. The service-active register can only be read.

Top module: `irq_core_ctrl`

## Requirements
- R1: After reset the mask, latch and active registers read zero and `grant` is low.
- R2: A high bit on `src_req` sets the matching latch bit at the next clock edge, whatever the mask holds.
- R3: Address 0 is the mask register; a write stores `bus_wdata` and reads return it. Source i can only be granted while mask bit i is 1.
- R4: A source is eligible when its latch and mask bits are both 1. Among the eligible sources, the one with the lowest index is chosen, and its index appears on `grant_idx`.
- R5: A grant decided at a clock edge clears the latch bit and sets the active bit at that same edge. `grant` is high for exactly the cycle that follows, with `grant_idx` valid.
- R6: A source is granted only if its index is strictly lower than every bit set in the active register. A more urgent source therefore nests over a running routine, and a less urgent one waits in the latch.
- R7: A cycle with `ret_strobe` high clears the lowest-index set bit of the active register. When no bit is set, it changes nothing.
- R8: If a source requests in the same cycle that its latch bit is cleared by a grant, the latch bit stays set.
- R9: Address 1 is the latch register. Writing 1 to a bit clears it and writing 0 leaves it alone. A request arriving in the same cycle overrides the clear.
- R10: Address 2 is the active register and is read-only, so writes to it have no effect. Address 3 reads zero.
- R11: When a grant and a return happen in the same cycle, the grant is decided against the active register as it was before the return. Both updates then take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | N | Source request lines, one per source |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 2 | Register select: 0 mask, 1 latch, 2 active |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data for `bus_addr`, combinational |
| ret_strobe | input | 1 | Return-from-interrupt pulse from the core |
| grant | output | 1 | One-cycle grant strobe to the core |
| grant_idx | output | $clog2(N) | Index of the granted source |

## Verification
Two groups of results follow a stimulus at different delays. Latch, mask and active-register updates show on `bus_rdata` in the cycle after the edge that consumes the stimulus. A grant strobe appears one edge after the latch and mask bits are both set, so a request followed by an enable write shows up two edges later. The bench drives inputs just after the falling edge. A behavioural model advances on each rising edge, and the comparison runs at the next falling edge, so every registered result is sampled in the first cycle it is due. Directed sequences add hand-computed checks for nesting, return ordering, the request-versus-clear races and the combined grant-with-return case.

// File: rtl/irq_core_ctrl.sv
module irq_core_ctrl #(
  parameter int N = 16,
  localparam int VW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_req,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  input  logic          ret_strobe,
  output logic          grant,
  output logic [VW-1:0] grant_idx
);
  localparam logic [1:0] A_MASK  = 2'd0;
  localparam logic [1:0] A_LATCH = 2'd1;
  localparam logic [1:0] A_ACT   = 2'd2;

  logic [N-1:0]  mask_q, latch_q, act_q;
  logic [N-1:0]  cand, take_bits, ret_bits, w1c_bits;
  logic [VW-1:0] best_idx, top_idx;
  logic          best_ok, top_ok, take;

  assign cand = latch_q & mask_q;

  always_comb begin
    best_idx = '0;
    best_ok  = 1'b0;
    top_idx  = '0;
    top_ok   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        best_idx = VW'(i);
        best_ok  = 1'b1;
      end
      if (act_q[i]) begin
        top_idx = VW'(i);
        top_ok  = 1'b1;
      end
    end
  end

  assign take      = best_ok && (!top_ok || best_idx < top_idx);
  assign take_bits = take ? (N'(1) << best_idx) : '0;
  assign ret_bits  = (ret_strobe && top_ok) ? (N'(1) << top_idx) : '0;
  assign w1c_bits  = (bus_wr && bus_addr == A_LATCH) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      latch_q   <= '0;
      act_q     <= '0;
      grant     <= 1'b0;
      grant_idx <= '0;
    end else begin
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata;
      latch_q <= (latch_q & ~take_bits & ~w1c_bits) | src_req;
      act_q   <= (act_q & ~ret_bits) | take_bits;
      grant   <= take;
      if (take) grant_idx <= best_idx;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MASK:  bus_rdata = mask_q;
      A_LATCH: bus_rdata = latch_q;
      A_ACT:   bus_rdata = act_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_latch_keeps_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req != '0) |=> ((latch_q & $past(src_req)) == $past(src_req)));

  assert_grant_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ((($past(cand) >> grant_idx) & N'(1)) != '0) &&
              (($past(cand) & ~({N{1'b1}} << grant_idx)) == '0));

  assert_grant_marks_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (((act_q >> grant_idx) & N'(1)) != '0));

  assert_nest_outranks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (($past(act_q) & ~({N{1'b1}} << grant_idx)) == '0) &&
              ((($past(act_q) >> grant_idx) & N'(1)) == '0));

  assert_return_drops_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && act_q != '0 && !take) |=>
      ($countones(act_q) == $countones($past(act_q)) - 1));

  assert_active_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_strobe && !take) |=> (act_q == $past(act_q)));
endmodule

// File: tb/tb_irq_core_ctrl.sv
module tb_irq_core_ctrl;
  localparam int N = 8;
  localparam int VW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          wr = 1'b0;
  logic [1:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic          ret = 1'b0;
  logic [N-1:0]  rdata;
  logic          gnt;
  logic [VW-1:0] gidx;

  irq_core_ctrl #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .src_req(src), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .ret_strobe(ret),
    .grant(gnt), .grant_idx(gidx)
  );

  int tests = 0, fails = 0, cycles = 0;

  logic [N-1:0] m_mask, m_lat, m_act, nl, na;
  logic m_gnt;
  int m_idx, best, top;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL R1 watchdog: act=%0d cycles exp<50000", cycles);
      summary();
    end
    if (!rst_n) begin
      m_mask = '0; m_lat = '0; m_act = '0; m_gnt = 1'b0; m_idx = 0;
    end else begin
      best = -1;
      top = N;
      for (int i = N - 1; i >= 0; i--) begin
        if (m_lat[i] && m_mask[i]) best = i;
        if (m_act[i]) top = i;
      end
      nl = m_lat;
      na = m_act;
      if (wr && addr == 2'd1) nl = nl & ~wdata;
      if (ret && top < N) na[top] = 1'b0;
      m_gnt = (best >= 0 && best < top);
      if (m_gnt) begin
        nl[best] = 1'b0;
        na[best] = 1'b1;
        m_idx = best;
      end
      nl = nl | src;
      if (wr && addr == 2'd0) m_mask = wdata;
      m_lat = nl;
      m_act = na;
    end
  end

  function automatic logic [N-1:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_mask;
      2'd1: return m_lat;
      2'd2: return m_act;
      default: return '0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      chk(gnt === m_gnt, "R5 grant strobe", 32'(gnt), 32'(m_gnt));
      if (m_gnt) chk(gidx === m_idx[VW-1:0], "R4 grant index", 32'(gidx), 32'(m_idx));
      chk(rdata === m_read(addr), "R3/R9/R10 readback", 32'(rdata), 32'(m_read(addr)));
    end
  endtask

  task automatic drive(logic [N-1:0] s, logic w, logic [1:0] a, logic [N-1:0] d, logic r);
    src = s; wr = w; addr = a; wdata = d; ret = r;
  endtask

  task automatic cyc(logic [N-1:0] s, logic w, logic [1:0] a, logic [N-1:0] d, logic r);
    tick();
    drive(s, w, a, d, r);
  endtask

  task automatic rd(logic [1:0] a, output logic [N-1:0] v);
    tick();
    drive('0, 1'b0, a, '0, 1'b0);
    #1 v = rdata;
  endtask

  logic [N-1:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); chk(v == 8'h00, "R1 mask after reset", 32'(v), 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 latch after reset", 32'(v), 0);
    rd(2'd2, v); chk(v == 8'h00, "R1 active after reset", 32'(v), 0);
    chk(gnt == 1'b0, "R1 grant after reset", 32'(gnt), 0);

    cyc(8'h08, 0, 0, 0, 0);
    rd(2'd1, v); chk(v == 8'h08, "R2 masked request latched", 32'(v), 8);
    cyc(0, 1, 2'd0, 8'h2A, 0);
    cyc(0, 0, 0, 0, 0);
    rd(2'd2, v); chk(v == 8'h08, "R5 active set on grant", 32'(v), 8);
    rd(2'd1, v); chk(v == 8'h00, "R5 latch cleared on grant", 32'(v), 0);
    rd(2'd0, v); chk(v == 8'h2A, "R3 mask readback", 32'(v), 8'h2A);

    cyc(8'h20, 0, 0, 0, 0);
    rd(2'd2, v); chk(v == 8'h08, "R6 lower priority waits", 32'(v), 8);
    rd(2'd1, v); chk(v == 8'h20, "R6 lower priority stays latched", 32'(v), 8'h20);
    cyc(8'h02, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    rd(2'd2, v); chk(v == 8'h0A, "R6 nested grant", 32'(v), 8'h0A);

    cyc(0, 0, 0, 0, 1);
    rd(2'd2, v); chk(v == 8'h08, "R7 return clears most urgent", 32'(v), 8);
    cyc(0, 0, 0, 0, 1);
    rd(2'd2, v); chk(v == 8'h00, "R7 return clears last", 32'(v), 0);
    rd(2'd2, v); chk(v == 8'h20, "R6 waiting source granted after return", 32'(v), 8'h20);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    rd(2'd2, v); chk(v == 8'h00, "R7 return on empty is harmless", 32'(v), 0);

    cyc(0, 1, 2'd0, 8'h00, 0);
    cyc(8'h40, 0, 0, 0, 0);
    rd(2'd1, v); chk(v == 8'h40, "R9 latch set", 32'(v), 8'h40);
    cyc(0, 1, 2'd1, 8'h40, 0);
    rd(2'd1, v); chk(v == 8'h00, "R9 write-one clears", 32'(v), 0);
    cyc(8'h40, 1, 2'd1, 8'h40, 0);
    rd(2'd1, v); chk(v == 8'h40, "R9 request beats clear", 32'(v), 8'h40);
    cyc(0, 1, 2'd1, 8'hFF, 0);

    cyc(0, 1, 2'd2, 8'hFF, 0);
    rd(2'd2, v); chk(v == 8'h00, "R10 active ignores writes", 32'(v), 0);
    rd(2'd3, v); chk(v == 8'h00, "R10 unused address reads zero", 32'(v), 0);

    cyc(0, 1, 2'd0, 8'h80, 0);
    cyc(8'h80, 0, 0, 0, 0);
    cyc(8'h80, 0, 0, 0, 0);
    rd(2'd1, v); chk(v == 8'h80, "R8 request during grant kept", 32'(v), 8'h80);
    rd(2'd2, v); chk(v == 8'h80, "R8 grant still taken", 32'(v), 8'h80);
    cyc(0, 1, 2'd0, 8'h00, 1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 1, 2'd1, 8'hFF, 1);
    rd(2'd2, v); chk(v == 8'h00, "R7 cleanup active", 32'(v), 0);

    cyc(0, 1, 2'd0, 8'h03, 0);
    cyc(8'h02, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(8'h01, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    rd(2'd2, v); chk(v == 8'h01, "R11 grant and return together", 32'(v), 1);
    cyc(0, 0, 0, 0, 1);

    cyc(0, 1, 2'd0, 8'h0C, 0);
    cyc(8'h0C, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    tick();
    chk(gnt == 1'b1 && gidx == 3'd2, "R4 lowest index wins", {28'(gnt), 1'b0, gidx}, {28'd1, 1'b0, 3'd2});
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);

    for (int k = 0; k < 800; k++) begin
      cyc(($urandom % 3 == 0) ? (N'($urandom) & N'($urandom)) : '0,
          ($urandom % 6 == 0), 2'($urandom), N'($urandom), ($urandom % 4 == 0));
    end
    tick();
    summary();
  end
endmodule